// File: doc/BRIEF.md
# Dual-Chain Carry-Select Arithmetic Unit

This block is an N-bit arithmetic datapath made of identical per-bit cells. Each cell works out two results in advance: one as if the carry entering the block were 0 and one as if it were 1. Each cell therefore keeps two carry chains. A single chain select at the block level then picks which set of sums and which final carry-out is used. The carry-in does not ripple through the bits.

The same datapath serves three uses, chosen by a two-bit mode input:

- **Plain adder/subtractor** on two operand inputs.
- **Accumulator**, which adds to or subtracts from its own register.
- **Up/down counter**, which steps its register by one.

The result appears on a combinational output and on a registered output. The register has these synchronous controls: clock enable, clear, parallel load, counter enable and up/down direction.

Top module: `dcs_arith_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc_q` becomes 0 and `acc_cout_q` becomes 0.
- R2: In arithmetic mode (`op_mode` = 2'b00) with `add_sel` = 1, `{res_cout, res_sum}` equals `opnd_x + opnd_y + carry_in`. This is an (N+1)-bit result.
- R3: In arithmetic mode with `add_sel` = 0, `res_sum` equals `opnd_x - opnd_y` modulo 2^N. `res_cout` is 1 exactly when `opnd_x >= opnd_y` (no borrow). `carry_in` has no effect.
- R4: The result built on the 1-assumed chain always equals the result on the 0-assumed chain plus one. The chain select picks between these two precomputed results.
- R5: When `clk_en` = 1 and neither `sync_clr` nor `sync_ld` is set, a rising edge in arithmetic mode copies `res_sum` into `acc_q` and `res_cout` into `acc_cout_q`.
- R6: When `clk_en` = 0, `acc_q` and `acc_cout_q` hold their values, whatever the other controls are.
- R7: When `clk_en` = 1 and `sync_clr` = 1, both registers become 0. This takes priority over load and over every update.
- R8: When `clk_en` = 1, `sync_clr` = 0 and `sync_ld` = 1, `acc_q` takes `ld_value` and `acc_cout_q` becomes 0.
- R9: In counter mode (`op_mode` = 2'b10) with `dir_up` = 1, `res_sum` is `acc_q + 1`. When `cnt_en` = 1, the register takes that value. Stepping from all-ones wraps to 0, and `acc_cout_q` = 1 on that step. `add_sel` and the operands have no effect in this mode.
- R10: In counter mode with `dir_up` = 0, the unit adds all-ones, so `acc_q` decrements. Stepping from 0 wraps to all-ones with `acc_cout_q` = 0. Every other down step sets `acc_cout_q` to 1.
- R11: In counter mode with `cnt_en` = 0, the registers hold.
- R12: In accumulator mode (`op_mode` = 2'b01), the result is `acc_q + opnd_y + carry_in` when `add_sel` = 1, and `acc_q - opnd_y` when `add_sel` = 0. On each enabled edge the register takes that result. Mode 2'b11 behaves as arithmetic mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Gates every register update |
| sync_clr | input | 1 | Synchronous clear of the registers |
| sync_ld | input | 1 | Synchronous parallel load |
| cnt_en | input | 1 | Counter step enable (counter mode) |
| dir_up | input | 1 | Count direction, 1 = up |
| add_sel | input | 1 | 1 = add, 0 = subtract |
| op_mode | input | 2 | 00 arithmetic, 01 accumulate, 10 count, 11 arithmetic |
| carry_in | input | 1 | Block carry-in when adding |
| opnd_x | input | N | First operand (arithmetic mode) |
| opnd_y | input | N | Second operand |
| ld_value | input | N | Parallel load value |
| res_sum | output | N | Combinational result |
| res_cout | output | 1 | Combinational carry-out |
| acc_q | output | N | Registered result |
| acc_cout_q | output | 1 | Registered carry-out |

## Verification
A table of operand pairs exercises addition and subtraction:

- **Carry-in.** Pairs are applied with carry-in 0 and with carry-in 1. This shows whether the select really switches chains. Pairs whose carry travels the full width, such as 0x0F + 0xF0 + 1, show whether the 1-assumed chain propagates across every bit.
- **Subtraction.** Pairs with and without a borrow separate the forced carry of subtraction from the external carry-in.

Directed sequences then cover the register:

- **Counter.** The counter is walked through both wrap points, in each direction. This checks the carry-out on each side of the wrap.
- **Controls.** Clear and load are asserted together, and clock enable is held low while they are active. This shows the priority order.
- **Accumulator.** Accumulator steps confirm that the register value, not the operand port, feeds the adder.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    MODE_ARITH = 2'b00,
    MODE_ACCUM = 2'b01,
    MODE_COUNT = 2'b10,
    MODE_SPARE = 2'b11
  } dcs_mode_e;
endpackage

// File: rtl/dcs_bit_cell.sv
// One bit of the dual-chain datapath: two candidate sums and two carry-outs.
module dcs_bit_cell (
  input  logic x_bit,
  input  logic y_bit,
  input  logic cin_lo,    // incoming carry on the 0-assumed chain
  input  logic cin_hi,    // incoming carry on the 1-assumed chain
  output logic sum_lo,
  output logic sum_hi,
  output logic cout_lo,
  output logic cout_hi
);
  logic gen_b, prop_b, co_if_zero, co_if_one;

  always_comb begin
    gen_b      = x_bit & y_bit;
    prop_b     = x_bit ^ y_bit;
    co_if_zero = gen_b;
    co_if_one  = gen_b | prop_b;
    sum_lo     = prop_b ^ cin_lo;
    sum_hi     = prop_b ^ cin_hi;
    cout_lo    = cin_lo ? co_if_one : co_if_zero;
    cout_hi    = cin_hi ? co_if_one : co_if_zero;
  end
endmodule

// File: rtl/dcs_carry_chain.sv
// N cells wired into two speculative chains; a block select picks one.
module dcs_carry_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_vec,
  input  logic [WIDTH-1:0] y_vec,
  input  logic             chain_sel,
  output logic [WIDTH-1:0] cand_sum_lo,
  output logic [WIDTH-1:0] cand_sum_hi,
  output logic             cand_cout_lo,
  output logic             cand_cout_hi,
  output logic [WIDTH-1:0] sum_out,
  output logic             cout_out
);
  logic [WIDTH:0] carry_lo;
  logic [WIDTH:0] carry_hi;

  assign carry_lo[0] = 1'b0;
  assign carry_hi[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    dcs_bit_cell u_cell (
      .x_bit   (x_vec[i]),
      .y_bit   (y_vec[i]),
      .cin_lo  (carry_lo[i]),
      .cin_hi  (carry_hi[i]),
      .sum_lo  (cand_sum_lo[i]),
      .sum_hi  (cand_sum_hi[i]),
      .cout_lo (carry_lo[i+1]),
      .cout_hi (carry_hi[i+1])
    );
  end

  assign cand_cout_lo = carry_lo[WIDTH];
  assign cand_cout_hi = carry_hi[WIDTH];

  always_comb begin
    sum_out  = chain_sel ? cand_sum_hi  : cand_sum_lo;
    cout_out = chain_sel ? cand_cout_hi : cand_cout_lo;
  end
endmodule

// File: rtl/dcs_operand_sel.sv
// Chooses the two adder inputs and the chain select for the current mode.
module dcs_operand_sel
  import dcs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  dcs_mode_e        mode,
  input  logic             add_sel,
  input  logic             dir_up,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] x_vec,
  output logic [WIDTH-1:0] y_vec,
  output logic             chain_sel
);
  localparam logic [WIDTH-1:0] STEP_UP   = WIDTH'(1);
  localparam logic [WIDTH-1:0] STEP_DOWN = '1;

  logic [WIDTH-1:0] y_signed;
  logic             sel_arith;

  always_comb begin
    y_signed  = add_sel ? opnd_y : ~opnd_y;
    sel_arith = add_sel ? carry_in : 1'b1;
    unique case (mode)
      MODE_ACCUM: begin
        x_vec     = acc_q;
        y_vec     = y_signed;
        chain_sel = sel_arith;
      end
      MODE_COUNT: begin
        x_vec     = acc_q;
        y_vec     = dir_up ? STEP_UP : STEP_DOWN;
        chain_sel = 1'b0;
      end
      default: begin
        x_vec     = opnd_x;
        y_vec     = y_signed;
        chain_sel = sel_arith;
      end
    endcase
  end
endmodule

// File: rtl/dcs_arith_unit.sv
module dcs_arith_unit
  import dcs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             sync_clr,
  input  logic             sync_ld,
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic             add_sel,
  input  logic [1:0]       op_mode,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [WIDTH-1:0] ld_value,
  output logic [WIDTH-1:0] res_sum,
  output logic             res_cout,
  output logic [WIDTH-1:0] acc_q,
  output logic             acc_cout_q
);
  localparam logic [WIDTH-1:0] ZERO_V = '0;
  localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);

  dcs_mode_e        mode;
  logic [WIDTH-1:0] x_vec, y_vec;
  logic             chain_sel;
  logic [WIDTH-1:0] cand_sum_lo, cand_sum_hi;
  logic             cand_cout_lo, cand_cout_hi;
  logic             step_ok;

  assign mode = dcs_mode_e'(op_mode);

  dcs_operand_sel #(.WIDTH(WIDTH)) u_opsel (
    .mode      (mode),
    .add_sel   (add_sel),
    .dir_up    (dir_up),
    .carry_in  (carry_in),
    .opnd_x    (opnd_x),
    .opnd_y    (opnd_y),
    .acc_q     (acc_q),
    .x_vec     (x_vec),
    .y_vec     (y_vec),
    .chain_sel (chain_sel)
  );

  dcs_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .x_vec        (x_vec),
    .y_vec        (y_vec),
    .chain_sel    (chain_sel),
    .cand_sum_lo  (cand_sum_lo),
    .cand_sum_hi  (cand_sum_hi),
    .cand_cout_lo (cand_cout_lo),
    .cand_cout_hi (cand_cout_hi),
    .sum_out      (res_sum),
    .cout_out     (res_cout)
  );

  // The counter only steps when its enable is set; other modes step each enabled edge.
  assign step_ok = (mode != MODE_COUNT) || cnt_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= ZERO_V;
      acc_cout_q <= 1'b0;
    end else if (clk_en) begin
      if (sync_clr) begin
        acc_q      <= ZERO_V;
        acc_cout_q <= 1'b0;
      end else if (sync_ld) begin
        acc_q      <= ld_value;
        acc_cout_q <= 1'b0;
      end else if (step_ok) begin
        acc_q      <= res_sum;
        acc_cout_q <= res_cout;
      end
    end
  end

  // R4
  chain_offset_chk: assert property (@(posedge clk) disable iff (rst)
    {cand_cout_hi, cand_sum_hi} == {cand_cout_lo, cand_sum_lo} + {1'b0, ONE_V});

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == ZERO_V) && !acc_cout_q);

  // R6
  hold_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(acc_q) && $stable(acc_cout_q));

  // R7
  clear_first_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sync_clr) |=> (acc_q == ZERO_V) && !acc_cout_q);

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sync_clr && sync_ld) |=> (acc_q == $past(ld_value)) && !acc_cout_q);

  // R9
  count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sync_clr && !sync_ld && op_mode == 2'b10 && cnt_en && dir_up)
      |=> acc_q == $past(acc_q) + ONE_V);

  // R11
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sync_clr && !sync_ld && op_mode == 2'b10 && !cnt_en)
      |=> $stable(acc_q));

  // R3
  subtract_chk: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 2'b00 && !add_sel) |-> res_sum == opnd_x - opnd_y);
endmodule

// File: tb/test_dcs_arith_unit.sv
module test_dcs_arith_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  // {add_sel, carry_in, x, y, exp_cout, exp_sum}
  localparam logic [26:0] VECS [12] = '{
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 8'h01},
    {1'b1, 1'b0, 8'hFF, 8'h01, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, 8'hFF},
    {1'b1, 1'b0, 8'h3C, 8'h42, 1'b0, 8'h7E},
    {1'b1, 1'b1, 8'h80, 8'h7F, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h50, 8'h20, 1'b1, 8'h30},
    {1'b0, 1'b1, 8'h20, 8'h50, 1'b0, 8'hD0},
    {1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 8'hFF},
    {1'b0, 1'b1, 8'hAA, 8'hAA, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'h0F, 8'hF0, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'h0F, 8'hF0, 1'b0, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst, clk_en, sync_clr, sync_ld, cnt_en, dir_up, add_sel, carry_in;
  logic [1:0]   op_mode;
  logic [W-1:0] opnd_x, opnd_y, ld_value;
  logic [W-1:0] res_sum, acc_q;
  logic         res_cout, acc_cout_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcs_arith_unit #(.WIDTH(W)) i_dcs_arith_unit (
    .clk, .rst, .clk_en, .sync_clr, .sync_ld, .cnt_en, .dir_up, .add_sel,
    .op_mode, .carry_in, .opnd_x, .opnd_y, .ld_value,
    .res_sum, .res_cout, .acc_q, .acc_cout_q
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance one clock edge and settle past it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_ctrl();
    clk_en = 1'b1; sync_clr = 1'b0; sync_ld = 1'b0; cnt_en = 1'b0;
    dir_up = 1'b1; add_sel = 1'b1; carry_in = 1'b0; op_mode = 2'b00;
    opnd_x = '0; opnd_y = '0; ld_value = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle_ctrl();
    rst = 1'b1;
    opnd_x = 8'h55; opnd_y = 8'h22;
    tick(); tick();
    // R1: reset clears both registers
    check("R1", {acc_cout_q, acc_q}, 9'h000);
    rst = 1'b0;

    // R2 R3 R4 R5: table walk in arithmetic mode
    foreach (VECS[i]) begin
      add_sel  = VECS[i][26];
      carry_in = VECS[i][25];
      opnd_x   = VECS[i][24:17];
      opnd_y   = VECS[i][16:9];
      #1;
      check(VECS[i][26] ? "R2/R4 comb add" : "R3 comb sub",
            {res_cout, res_sum}, VECS[i][8:0]);
      tick();
      check("R5 registered", {acc_cout_q, acc_q}, VECS[i][8:0]);
    end

    // R8: load
    idle_ctrl();
    sync_ld = 1'b1; ld_value = 8'hFE;
    tick();
    check("R8 load", {acc_cout_q, acc_q}, 9'h0FE);

    // R9: count up across the wrap; operands and add_sel must not matter
    idle_ctrl();
    op_mode = 2'b10; cnt_en = 1'b1; dir_up = 1'b1;
    add_sel = 1'b0; opnd_x = 8'h33; opnd_y = 8'h44; carry_in = 1'b1;
    #1;
    check("R9 comb up", {res_cout, res_sum}, 9'h0FF);
    tick(); check("R9 up", {acc_cout_q, acc_q}, 9'h0FF);
    tick(); check("R9 wrap", {acc_cout_q, acc_q}, 9'h100);
    tick(); check("R9 after wrap", {acc_cout_q, acc_q}, 9'h001);

    // R11: counter enable low holds
    cnt_en = 1'b0;
    tick(); tick();
    check("R11 hold", {acc_cout_q, acc_q}, 9'h001);

    // R10: count down across the wrap
    cnt_en = 1'b1; dir_up = 1'b0;
    tick(); check("R10 down", {acc_cout_q, acc_q}, 9'h100);
    tick(); check("R10 wrap", {acc_cout_q, acc_q}, 9'h0FF);

    // R6: clock enable low overrides clear and load
    clk_en = 1'b0; sync_clr = 1'b1; sync_ld = 1'b1; ld_value = 8'h5A;
    tick(); tick();
    check("R6 gated", {acc_cout_q, acc_q}, 9'h0FF);

    // R7: clear beats load
    clk_en = 1'b1;
    tick();
    check("R7 clear priority", {acc_cout_q, acc_q}, 9'h000);

    // R12: accumulate add then subtract
    idle_ctrl();
    sync_ld = 1'b1; ld_value = 8'h10;
    tick();
    sync_ld = 1'b0; op_mode = 2'b01; add_sel = 1'b1; carry_in = 1'b1;
    opnd_x = 8'hEE; opnd_y = 8'h05;
    tick(); check("R12 acc add", {acc_cout_q, acc_q}, 9'h016);
    add_sel = 1'b0; opnd_y = 8'h06;
    tick(); check("R12 acc sub", {acc_cout_q, acc_q}, 9'h110);

    // R12: spare mode code behaves as arithmetic
    op_mode = 2'b11; add_sel = 1'b1; carry_in = 1'b0;
    opnd_x = 8'h21; opnd_y = 8'h12;
    #1;
    check("R12 spare mode", {res_cout, res_sum}, 9'h033);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule